// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block is the per-processor half of a load-exclusive / store-exclusive scheme. A load-exclusive arms a single reservation. The reservation holds the address with its granule offset bits dropped, together with the access size. A later store-exclusive is tested against that reservation. The block answers each request with a one-bit status, where 0 means the store may proceed and 1 means it was refused. When the store proceeds, the block raises a one-cycle write enable toward memory. Every store-exclusive consumes the reservation, whether it passes or fails. A separate clear input drops the reservation at any time.

For shareable accesses a passing local check is not enough. The block forwards the access to a shared global monitor over a request channel and then waits for that monitor's verdict. Shareable load-exclusives are also forwarded, so the global side can record its own mark. The processor side is a valid/ready stream with one request in flight. Back-pressure works in both directions. `req_ready` stays low from the moment a request is accepted until its response has been taken. The response is held, unchanged, for as long as `rsp_ready` is low.

Top module: `excl_monitor`

## Requirements
- R1: After reset no reservation exists, `req_ready` is 1, and `rsp_valid`, `mem_we` and `gm_req_valid` are 0. A store-exclusive issued before any load-exclusive fails with status 1.
- R2: An accepted load-exclusive (`req_op`=0) arms the reservation with the tag `req_addr[ADDR_W-1:GRAN_W]` and with `req_size`. Its status is 0. A load-exclusive accepted while a reservation already exists replaces the old one.
- R3: A non-shareable store-exclusive (`req_op`=1) succeeds, with status 0, only when a reservation exists, its tag equals the store's tag and its size code equals the store's size code. Size codes are 0 for byte, 1 for halfword, 2 for word and 3 for doubleword. In every other case the status is 1.
- R4: Every accepted store-exclusive removes the reservation, whatever its outcome. A second store-exclusive with no new load-exclusive in between therefore fails.
- R5: While `clrex` is 1 at a clock edge, the reservation is removed. If a load-exclusive is accepted on that same edge, the clear wins and no reservation is left.
- R6: A non-shareable request accepted at edge k shows `rsp_valid` from the cycle after edge k. `mem_we` is 1 only in that first response cycle, and only for a successful store. During that cycle `mem_addr` carries the full store address.
- R7: The response stays valid with a stable `rsp_status` until it is taken with `rsp_ready`. `req_ready` is 0 while any request is still in flight.
- R8: A shareable store-exclusive that fails the local check returns status 1 and sends nothing to the global monitor. A shareable store-exclusive that passes the local check raises `gm_req_valid`, with `gm_req_store`=1 and the full address. That request is held until `gm_req_ready` is 1. The response then appears in the cycle after `gm_rsp_valid` is sampled, and the store succeeds exactly when `gm_rsp_ok` was 1.
- R9: A shareable load-exclusive is forwarded with `gm_req_store`=0. It returns status 0 whatever verdict comes back, and it never raises `mem_we`.
- R10: Address bits below `GRAN_W` (6 with the default 64-byte granule) play no part in the match. A store to another byte of the same granule can succeed, and a store to the next granule fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Monitor can accept a request |
| req_op | input | 1 | 0 = load-exclusive, 1 = store-exclusive |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| req_shared | input | 1 | Access targets shareable memory |
| clrex | input | 1 | Drop the reservation |
| rsp_valid | output | 1 | Status available |
| rsp_ready | input | 1 | Processor takes the status |
| rsp_status | output | 1 | 0 = success, 1 = failure |
| mem_we | output | 1 | One-cycle write enable for a successful store |
| mem_addr | output | ADDR_W | Address of the in-flight access |
| gm_req_valid | output | 1 | Request to the global monitor |
| gm_req_ready | input | 1 | Global monitor takes the request |
| gm_req_store | output | 1 | Forwarded access is a store-exclusive |
| gm_req_addr | output | ADDR_W | Forwarded address |
| gm_rsp_valid | input | 1 | Global verdict present |
| gm_rsp_ok | input | 1 | Global monitor holds a mark for this processor |

## Verification
The assertions check the per-cycle rules on every cycle:
- the write enable always coincides with a successful response and lasts one cycle;
- a stalled response, or a stalled global request, holds its value;
- the reservation is set, kept or removed on exactly the edges given by R2, R4 and R5;
- a non-shareable request always answers on the next cycle.

Only the bench's scenarios can show that the pass/fail decision is right. That covers every pairing of load size and store size, addresses inside and outside the granule, reloads, clears that coincide with a load, and the full grid of local result against global verdict with a stalled global request.

// File: rtl/excl_pkg.sv
package excl_pkg;

  // access size codes carried on req_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  // request sequencing states
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GREQ = 2'd1,
    ST_GRSP = 2'd2,
    ST_RESP = 2'd3
  } ctl_state_e;

endpackage

// File: rtl/excl_resv.sv
module excl_resv
  import excl_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             consume,
  input  logic             clr,
  input  logic [TAG_W-1:0] tag_in,
  input  acc_size_e        size_in,
  output logic             hit,
  output logic             held
);

  logic [TAG_W-1:0] tag_q;
  acc_size_e        size_q;
  logic             held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      tag_q  <= '0;
      size_q <= SZ_BYTE;
    end else if (clr || consume) begin
      held_q <= 1'b0;
    end else if (arm) begin
      held_q <= 1'b1;
      tag_q  <= tag_in;
      size_q <= size_in;
    end
  end

  assign hit  = held_q && (tag_q == tag_in) && (size_q == size_in);
  assign held = held_q;

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !held);
  assert_consume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !held);
  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !clr) |=> held);

endmodule

// File: rtl/excl_ctrl.sv
module excl_ctrl
  import excl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_op,
  input  logic req_shared,
  input  logic local_hit,
  input  logic gm_req_ready,
  input  logic gm_rsp_valid,
  input  logic gm_rsp_ok,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic rsp_valid,
  output logic rsp_status,
  output logic mem_we,
  output logic gm_req_valid,
  output logic gm_req_store
);

  ctl_state_e state_q;
  logic       is_store_q;
  logic       status_q;
  logic       we_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      is_store_q <= 1'b0;
      status_q   <= 1'b0;
      we_q       <= 1'b0;
    end else begin
      we_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          is_store_q <= req_op;
          if (req_shared && (!req_op || local_hit)) begin
            state_q <= ST_GREQ;
          end else begin
            state_q  <= ST_RESP;
            status_q <= req_op && !local_hit;
            we_q     <= req_op && local_hit;
          end
        end
        ST_GREQ: if (gm_req_ready) state_q <= ST_GRSP;
        ST_GRSP: if (gm_rsp_valid) begin
          state_q  <= ST_RESP;
          status_q <= is_store_q && !gm_rsp_ok;
          we_q     <= is_store_q && gm_rsp_ok;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_status   = status_q;
  assign mem_we       = we_q;
  assign gm_req_valid = (state_q == ST_GREQ);
  assign gm_req_store = is_store_q;

  assert_we_success_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (rsp_valid && !rsp_status));
  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  assert_local_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_shared) |=> rsp_valid);
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status)));
  assert_one_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  assert_greq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_req_valid && !gm_req_ready) |=> (gm_req_valid && $stable(gm_req_store)));

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_shared,
  input  logic              clrex,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_status,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              gm_req_valid,
  input  logic              gm_req_ready,
  output logic              gm_req_store,
  output logic [ADDR_W-1:0] gm_req_addr,
  input  logic              gm_rsp_valid,
  input  logic              gm_rsp_ok
);

  localparam int GRAN_W = (GRAN_BYTES > 1) ? $clog2(GRAN_BYTES) : 0;
  localparam int TAG_W  = ADDR_W - GRAN_W;

  logic              accept;
  logic              local_hit;
  logic              resv_held;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  req_tag;

  generate
    if (GRAN_W > 0) begin : g_gran
      assign req_tag = req_addr[ADDR_W-1:GRAN_W];
    end else begin : g_byte
      assign req_tag = req_addr;
    end
  endgenerate

  excl_resv #(.TAG_W(TAG_W)) resv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (accept && !req_op),
    .consume (accept && req_op),
    .clr     (clrex),
    .tag_in  (req_tag),
    .size_in (acc_size_e'(req_size)),
    .hit     (local_hit),
    .held    (resv_held)
  );

  excl_ctrl ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_shared   (req_shared),
    .local_hit    (local_hit),
    .gm_req_ready (gm_req_ready),
    .gm_rsp_valid (gm_rsp_valid),
    .gm_rsp_ok    (gm_rsp_ok),
    .rsp_ready    (rsp_ready),
    .req_ready    (req_ready),
    .accept       (accept),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .mem_we       (mem_we),
    .gm_req_valid (gm_req_valid),
    .gm_req_store (gm_req_store)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  assign mem_addr    = addr_q;
  assign gm_req_addr = addr_q;

  assert_fail_without_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op && !req_shared && !resv_held) |=> (rsp_valid && rsp_status));
  assert_gaddr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gm_req_valid && !gm_req_ready) |=> $stable(gm_req_addr));

endmodule

// File: tb/excl_monitor_tb_top.sv
module excl_monitor_tb_top;

  localparam int AW = 32;
  localparam int GW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_shared = 1'b0;
  logic          clrex = 1'b0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_status;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic          gm_req_valid;
  logic          gm_req_ready = 1'b0;
  logic          gm_req_store;
  logic [AW-1:0] gm_req_addr;
  logic          gm_rsp_valid = 1'b0;
  logic          gm_rsp_ok = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench-side reservation model
  bit            m_held = 1'b0;
  logic [AW-1:0] m_tag = '0;
  logic [1:0]    m_size = '0;

  always #10 clk = ~clk;

  excl_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .req_shared(req_shared), .clrex(clrex), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_status(rsp_status), .mem_we(mem_we),
    .mem_addr(mem_addr), .gm_req_valid(gm_req_valid), .gm_req_ready(gm_req_ready),
    .gm_req_store(gm_req_store), .gm_req_addr(gm_req_addr),
    .gm_rsp_valid(gm_rsp_valid), .gm_rsp_ok(gm_rsp_ok)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one request; expectation computed from the model
  task automatic send(input bit op, input logic [AW-1:0] addr, input logic [1:0] sz,
                      input bit sh, input bit gok, input int gdly, input bit clr);
    bit loc_ok, exp_g, exp_st;
    loc_ok = m_held && (addr[AW-1:GW] == m_tag[AW-1:GW]) && (sz == m_size);
    exp_g  = sh && (!op || loc_ok);
    exp_st = op && (exp_g ? !gok : !loc_ok);
    @(negedge clk);
    chk("R7 idle ready", req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_size = sz;
    req_shared = sh; clrex = clr;
    @(negedge clk);
    req_valid = 1'b0; clrex = 1'b0;
    chk("R7 busy", req_ready, 0);
    if (exp_g) begin
      for (int i = 0; i < gdly; i++) begin
        chk("R8 greq held", gm_req_valid, 1);
        @(negedge clk);
      end
      chk("R8 greq valid", gm_req_valid, 1);
      chk("R8 R9 greq store", gm_req_store, op);
      chk("R8 greq addr", gm_req_addr, addr);
      chk("R8 no early rsp", rsp_valid, 0);
      gm_req_ready = 1'b1;
      @(negedge clk);
      gm_req_ready = 1'b0;
      chk("R8 greq dropped", gm_req_valid, 0);
      gm_rsp_valid = 1'b1; gm_rsp_ok = gok;
      @(negedge clk);
      gm_rsp_valid = 1'b0;
    end else begin
      chk("R8 no greq", gm_req_valid, 0);
    end
    chk(op ? "R3 rsp valid" : "R2 rsp valid", rsp_valid, 1);
    chk(op ? (sh ? "R8 status" : "R3 status") : "R2 R9 status", rsp_status, exp_st);
    chk("R6 we", mem_we, op && !exp_st);
    if (op && !exp_st) chk("R6 mem addr", mem_addr, addr);
    @(negedge clk);
    chk("R6 we one cycle", mem_we, 0);
    chk("R7 rsp taken", rsp_valid, 0);
    if (clr || op) m_held = 1'b0;
    else begin m_held = 1'b1; m_tag = addr; m_size = sz; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp", rsp_valid, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 greq", gm_req_valid, 0);
    send(1, 32'h0000_0100, 2, 0, 0, 0, 0);   // R1 store before any load fails

    // R3 R4 R10 sweep: all size pairs, same granule / next granule
    for (int ls = 0; ls < 4; ls++)
      for (int ss = 0; ss < 4; ss++)
        for (int g = 0; g < 2; g++) begin
          logic [AW-1:0] a, b;
          a = 32'h0000_4000 + (ls * 256) + (ss * 64) + 8;
          b = g ? a + 64 : {a[AW-1:GW], 6'((a[5:0] + 6'd37))};
          send(0, a, 2'(ls), 0, 0, 0, 0);
          send(1, b, 2'(ss), 0, 0, 0, 0);
          send(1, b, 2'(ss), 0, 0, 0, 0);    // R4 no reservation left
        end

    // R2 reload replaces old reservation
    send(0, 32'h0000_8000, 2, 0, 0, 0, 0);
    send(0, 32'h0000_9040, 1, 0, 0, 0, 0);
    send(1, 32'h0000_8000, 2, 0, 0, 0, 0);
    send(0, 32'h0000_9040, 1, 0, 0, 0, 0);
    send(0, 32'h0000_9040, 1, 0, 0, 0, 0);
    send(1, 32'h0000_907f, 1, 0, 0, 0, 0);

    // R5 clear alone, then clear together with a load
    send(0, 32'h0000_a000, 3, 0, 0, 0, 0);
    @(negedge clk); clrex = 1'b1; @(negedge clk); clrex = 1'b0;
    m_held = 1'b0;
    send(1, 32'h0000_a000, 3, 0, 0, 0, 0);
    send(0, 32'h0000_a000, 3, 0, 0, 0, 1);
    send(1, 32'h0000_a000, 3, 0, 0, 0, 0);

    // R8 R9 shareable grid: local hit/miss x global verdict x stall
    for (int lh = 0; lh < 2; lh++)
      for (int gk = 0; gk < 2; gk++)
        for (int d = 0; d < 3; d++) begin
          send(0, 32'h0001_0000, 2, 1, gk[0], d, 0);
          send(1, 32'h0001_0010, lh ? 2'd2 : 2'd0, 1, gk[0], d, 0);
        end

    // R7 back-pressure on the response
    send(0, 32'h0002_0000, 0, 0, 0, 0, 0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 1'b1; req_addr = 32'h0002_0001; req_size = 2'd0; req_shared = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 we first cycle", mem_we, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R7 rsp held", rsp_valid, 1);
      chk("R7 status held", rsp_status, 0);
      chk("R7 no accept", req_ready, 0);
      @(negedge clk);
      chk("R6 we once", mem_we, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R7 released", rsp_valid, 0);
    m_held = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule